// File: doc/BRIEF.md
# Two-Phase Restartable Tick Timer

This block measures two back-to-back intervals in units of an external tick pulse, typically one per millisecond. A start pulse arms it. Once a first programmable number of ticks has arrived, it raises a one-cycle `firstDone` pulse. It then counts a second programmable number of further ticks and raises a one-cycle `secondDone` pulse. After that it goes idle.

A start pulse that arrives at any time, including mid-phase, throws away the sequence in progress and begins the first phase again from zero. A typical user is a supervisory controller that needs a "grace period elapsed" event followed by an "alarm window over" event.

The tick itself comes from elsewhere. Both interval lengths are 16-bit inputs and are read live on every tick.

Top module: `dual_phase_timer`

## Requirements
- R1: After synchronous reset (`rst` high, active-high) both outputs are low and the timer is idle. Ticks that arrive before the first start produce no output.
- R2: Ticks are counted on clock edges where `tickIn` is high, starting with the first edge after the start edge. On the edge where the count reaches `firstCount`, `firstDone` goes high for the following cycle.
- R3: After the first phase ends, counting restarts from zero. The tick that ended the first phase is not counted again. `secondDone` pulses in the cycle after the edge where `secondCount` further ticks have been seen.
- R4: `startIn` high on an edge in either phase discards the count and re-enters the first phase with zero ticks. A tick on that same edge is not counted.
- R5: If `startIn` coincides with the tick that would complete a phase, the start wins and no done pulse is produced for that edge.
- R6: After `secondDone`, ticks are ignored and no further pulse appears until the next start.
- R7: A phase ends on the first tick at which its count is greater than or equal to the current value of its length input. A length of 0 therefore behaves like 1, and lowering a length mid-phase ends the phase on the next tick.
- R8: Each done output is high for exactly one cycle per completion, and the two outputs are never high in the same cycle.
- R9: The full 16-bit range is honoured: a length of 65535 ends the phase on exactly the 65535th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickIn | input | 1 | One-cycle tick event |
| startIn | input | 1 | One-cycle start / restart event |
| firstCount | input | CNT_W | Length of the first phase in ticks |
| secondCount | input | CNT_W | Length of the second phase in ticks |
| firstDone | output | 1 | Pulse at end of first phase |
| secondDone | output | 1 | Pulse at end of second phase |

## Verification
A wrong phase or a miscounted tick counter stays hidden until the next phase boundary. It then shows as a done pulse that is early, late, missing or duplicated by one or more ticks. A stale phase after a restart shows as a `secondDone` without its preceding `firstDone`. The per-cycle reference comparison therefore catches such a fault within at most one phase length of ticks after it occurs, and reports it at the very cycle the pulse is wrong.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;      // zero the tick counter
    logic count;      // advance the tick counter
    logic useSecond;  // compare against the second length
  } dpStrobe_t;

endpackage

// File: rtl/timer_dpath.sv
module timer_dpath
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] firstCount,
  input  logic [CNT_W-1:0] secondCount,
  output logic             reachTarget
);

  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] tickCnt;
  logic [SUM_W-1:0] tickNum;
  logic [CNT_W-1:0] target;
  logic [SUM_W-1:0] effTarget;

  always_comb begin
    target    = strobe.useSecond ? secondCount : firstCount;
    tickNum   = {1'b0, tickCnt} + SUM_W'(1);
    effTarget = (target == '0) ? SUM_W'(1) : {1'b0, target};
    reachTarget = (tickNum >= effTarget);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt <= '0;
    end else if (strobe.clear) begin
      tickCnt <= '0;
    end else if (strobe.count) begin
      tickCnt <= tickNum[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tickIn,
  input  logic      startIn,
  input  logic      reachTarget,
  output dpStrobe_t strobe,
  output logic      firstDone,
  output logic      secondDone
);

  phase_e phase, phaseNext;
  logic   active;
  logic   finishing;

  always_comb begin
    active    = (phase != PH_IDLE);
    finishing = active && tickIn && !startIn && reachTarget;

    strobe.count     = active && tickIn && !startIn;
    strobe.clear     = startIn || finishing;
    strobe.useSecond = (phase == PH_SECOND);

    phaseNext = phase;
    if (startIn) begin
      phaseNext = PH_FIRST;
    end else if (finishing) begin
      unique case (phase)
        PH_FIRST:  phaseNext = PH_SECOND;
        PH_SECOND: phaseNext = PH_IDLE;
        default:   phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      firstDone  <= 1'b0;
      secondDone <= 1'b0;
    end else begin
      phase      <= phaseNext;
      firstDone  <= finishing && (phase == PH_FIRST);
      secondDone <= finishing && (phase == PH_SECOND);
    end
  end

endmodule

// File: rtl/dual_phase_timer.sv
module dual_phase_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tickIn,
  input  logic             startIn,
  input  logic [CNT_W-1:0] firstCount,
  input  logic [CNT_W-1:0] secondCount,
  output logic             firstDone,
  output logic             secondDone
);

  dpStrobe_t strobe;
  logic      reachTarget;

  timer_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .tickIn      (tickIn),
    .startIn     (startIn),
    .reachTarget (reachTarget),
    .strobe      (strobe),
    .firstDone   (firstDone),
    .secondDone  (secondDone)
  );

  timer_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .firstCount  (firstCount),
    .secondCount (secondCount),
    .reachTarget (reachTarget)
  );

endmodule

// File: rtl/timer_checker.sv
module timer_checker (
  input logic clk,
  input logic rst,
  input logic startIn,
  input logic firstDone,
  input logic secondDone
);

  logic seenFirst;   // firstDone already fired since last start
  logic armSecond;   // firstDone fired and secondDone not yet

  always_ff @(posedge clk) begin
    if (rst || startIn) begin
      seenFirst <= 1'b0;
      armSecond <= 1'b0;
    end else begin
      if (firstDone) seenFirst <= 1'b1;
      if (firstDone) armSecond <= 1'b1;
      else if (secondDone) armSecond <= 1'b0;
    end
  end

  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(firstDone && secondDone)); // R8

  AST_FIRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    firstDone |=> !firstDone); // R8

  AST_SECOND_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    secondDone |=> !secondDone); // R8

  AST_START_SUPPRESSES: assert property (@(posedge clk) disable iff (rst)
    startIn |=> (!firstDone && !secondDone)); // R5

  AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (rst)
    secondDone |-> armSecond); // R3

  AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (rst)
    firstDone |-> !seenFirst); // R6

endmodule

bind dual_phase_timer timer_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .startIn    (startIn),
  .firstDone  (firstDone),
  .secondDone (secondDone)
);

// File: tb/sim_dual_phase_timer.sv
module sim_dual_phase_timer;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickIn = 1'b0;
  logic startIn = 1'b0;
  logic [CNT_W-1:0] firstCount = 16'd5;
  logic [CNT_W-1:0] secondCount = 16'd10;
  logic firstDone, secondDone;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curReq = "R1";
  int seenF = 0;
  int seenS = 0;

  // reference model state
  int  mPhase = 0;
  int  mCnt = 0;
  bit  expF = 1'b0;
  bit  expS = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_phase_timer #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .tickIn(tickIn), .startIn(startIn),
    .firstCount(firstCount), .secondCount(secondCount),
    .firstDone(firstDone), .secondDone(secondDone)
  );

  // behavioural reference, updated on each edge
  always @(posedge clk) begin
    int tgt;
    if (rst) begin
      mPhase = 0; mCnt = 0; expF = 0; expS = 0;
    end else begin
      expF = 0; expS = 0;
      if (startIn) begin
        mPhase = 1; mCnt = 0;
      end else if (tickIn && mPhase != 0) begin
        mCnt = mCnt + 1;
        tgt = (mPhase == 1) ? int'(firstCount) : int'(secondCount);
        if (tgt == 0) tgt = 1;
        if (mCnt >= tgt) begin
          if (mPhase == 1) begin expF = 1; mPhase = 2; end
          else begin expS = 1; mPhase = 0; end
          mCnt = 0;
        end
      end
    end
  end

  // per-cycle comparison away from the edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      checks++;
      if (firstDone !== expF || secondDone !== expS) begin
        errors++;
        $display("FAIL %s cycle %0d: actual first=%b second=%b expected first=%b second=%b",
                 curReq, cycles, firstDone, secondDone, expF, expS);
      end
      if (firstDone) seenF++;
      if (secondDone) seenS++;
    end
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input bit t, input bit s);
    @(negedge clk);
    tickIn = t; startIn = s;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(1, 0);
      for (int g = 0; g < gap; g++) step(0, 0);
    end
  endtask

  task automatic expectPulses(input string req, input int f, input int s);
    step(0, 0); step(0, 0);
    checks++;
    if (seenF != f || seenS != s) begin
      errors++;
      $display("FAIL %s pulse count: actual %0d/%0d expected %0d/%0d", req, seenF, seenS, f, s);
    end
    seenF = 0; seenS = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (firstDone !== 1'b0 || secondDone !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual %b%b expected 00", firstDone, secondDone);
    end
    rst = 1'b0;
    curReq = "R1"; ticks(20, 0); expectPulses("R1", 0, 0);

    // R2/R3: dense ticks, 5 then 10
    curReq = "R2"; step(0, 1); ticks(5, 0);
    curReq = "R3"; ticks(10, 0); expectPulses("R3", 1, 1);

    // R2/R3: sparse ticks
    curReq = "R2"; firstCount = 3; secondCount = 4;
    step(0, 1); ticks(7, 2); expectPulses("R2", 1, 1);

    // R6: ticks after completion ignored
    curReq = "R6"; ticks(30, 0); expectPulses("R6", 0, 0);

    // R4: restart in first phase, tick with start
    curReq = "R4"; firstCount = 5; secondCount = 3;
    step(0, 1); ticks(3, 0); step(1, 1); ticks(4, 0);
    expectPulses("R4", 0, 0);
    ticks(1, 0); ticks(3, 0); expectPulses("R4", 1, 1);

    // R4: restart in second phase
    step(0, 1); ticks(5, 0); ticks(2, 0); step(0, 1);
    ticks(5, 1); ticks(3, 0); expectPulses("R4", 2, 1);

    // R5: start coincides with completing tick
    curReq = "R5"; firstCount = 3;
    step(0, 1); ticks(2, 0); step(1, 1); expectPulses("R5", 0, 0);
    ticks(3, 0); ticks(2, 0); step(1, 1); expectPulses("R5", 1, 0);

    // R7: zero lengths behave as one
    curReq = "R7"; firstCount = 0; secondCount = 0;
    step(0, 1); ticks(1, 0); ticks(1, 0); expectPulses("R7", 1, 1);
    // R7: live lowering mid-phase
    firstCount = 20; secondCount = 2;
    step(0, 1); ticks(6, 0); firstCount = 4; ticks(1, 0); ticks(2, 0);
    expectPulses("R7", 1, 1);

    // R8: back-to-back pulses with length one, checked every cycle
    curReq = "R8"; firstCount = 1; secondCount = 1;
    step(0, 1); ticks(2, 0); expectPulses("R8", 1, 1);

    // R9: full 16-bit first length
    curReq = "R9"; firstCount = 16'hFFFF; secondCount = 2;
    step(0, 1); ticks(65534, 0); expectPulses("R9", 0, 0);
    ticks(1, 0); ticks(2, 0); expectPulses("R9", 1, 1);

    // R1: reset mid-sequence clears
    curReq = "R1"; firstCount = 4;
    step(0, 1); ticks(2, 0); rst = 1'b1; step(0, 0); rst = 1'b0;
    ticks(10, 0); expectPulses("R1", 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule